// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog

This block is an operating-system timer that software reaches through a small synchronous register port. A 32-bit up-counter advances by one on each cycle in which the external tick strobe is high. Four compare registers are checked against the counter on every tick. When the counter reaches a compare value and that channel is enabled, a sticky status bit is set. Each status bit drives its own level interrupt output. Software clears a status bit by writing a one to it.

The last compare channel also serves as a one-shot watchdog. When watchdog bit 0 is armed and the counter reaches compare value 3, the block emits a one-cycle reset request and clears the whole watchdog register. This happens whether interrupt 3 is enabled or not. The tick strobe comes from outside the block. Reads are combinational on the offset and have no side effects.

Top module: `os_timer_wdt`

## Requirements
- R1: After reset, the counter, the four compare registers, the interrupt enable, the watchdog register and the status all read zero. All interrupt outputs and the reset request are low.
- R2: Compare registers 0 to 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. Each reads back the full 32-bit value last written to it.
- R3: The counter is at offset 0x10. A write there loads the written value and takes priority over a tick in the same cycle. Otherwise each tick adds one, modulo 2^32, and without a tick the counter holds.
- R4: The interrupt enable is at offset 0x1C. A write there keeps bits 11:0, and bits 31:12 read as zero.
- R5: Channel n has a match when a tick moves the counter onto the value of compare register n. If enable bit n is set, status bit n (offset 0x14, bit n) is set on that same clock edge. Interrupt output n equals status bit n.
- R6: A match on a channel whose enable bit is clear changes neither its status bit nor its interrupt output.
- R7: A write to offset 0x14 clears exactly those status bits that are written as 1 and are currently set. The other status bits keep their value.
- R8: When a clearing write and a new match event hit the same status bit in one cycle, the bit stays set.
- R9: A match on compare register 3 while watchdog bit 0 (offset 0x18) is set has two results, whatever the enable bit 3 is. The reset request goes high for exactly one cycle, on the edge of the match. The watchdog register then reads zero, even if it was written in that same cycle.
- R10: A match on compare register 3 while watchdog bit 0 is clear raises no reset request.
- R11: A read of any unmapped offset returns zero. A write to any unmapped offset changes no register.
- R12: A counter load never produces a match, even when the loaded value equals a compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe for the counter |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 4 | Level interrupts, one per compare channel |
| rst_req_o | output | 1 | One-cycle system reset request from the watchdog |

## Verification
Most internal faults in this block reach the ports within one clock edge.

- A wrong counter increment, or a load that loses to a tick, shows at once when offset 0x10 is read back. It also moves every later match to the wrong edge.
- A compare against the wrong counter value makes an interrupt or a reset request appear one tick early or late.
- A faulty enable gate or clear mask leaves irq_o different from the expected status on the edge after the stimulus.
- A watchdog that fails to disarm itself is seen on the next read of offset 0x18.

// File: rtl/os_timer_pkg.sv
package os_timer_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned N_CH_DEF   = 4;
  localparam int unsigned IE_W_DEF   = 12;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned OFS_CNT    = 'h10;
  localparam int unsigned OFS_STAT   = 'h14;
  localparam int unsigned OFS_WDT    = 'h18;
  localparam int unsigned OFS_IE     = 'h1C;
  localparam int unsigned CH_STRIDE  = 4;
endpackage

// File: rtl/os_timer_counter.sv
module os_timer_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_inc_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;

  assign cnt_inc_o = cnt_q + W'(1);
  // a load suppresses the tick, so no match is seen on a load
  assign step_o    = tick_i & ~load_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_inc_o;
  end
endmodule

// File: rtl/os_timer_match_ch.sv
module os_timer_match_ch #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_inc_i,
  input  logic         step_i,
  output logic [W-1:0] match_o,
  output logic         hit_o
);
  logic [W-1:0] match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   match_q <= '0;
    else if (we_i) match_q <= wdata_i;
  end

  assign match_o = match_q;
  assign hit_o   = step_i && (cnt_inc_i == match_q);
endmodule

// File: rtl/os_timer_evt.sv
module os_timer_evt #(
  parameter int unsigned W    = 32,
  parameter int unsigned N_CH = 4,
  parameter int unsigned IE_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ie_we_i,
  input  logic            st_we_i,
  input  logic            wdt_we_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [N_CH-1:0] hit_i,
  output logic [IE_W-1:0] ie_o,
  output logic [N_CH-1:0] status_o,
  output logic [W-1:0]    wdt_o,
  output logic            rst_req_o
);
  localparam int unsigned WD_CH = N_CH - 1;

  logic [IE_W-1:0] ie_q;
  logic [N_CH-1:0] st_q;
  logic [W-1:0]    wdt_q;
  logic            rst_req_q;
  logic [N_CH-1:0] clr_mask;
  logic [N_CH-1:0] set_mask;
  logic            wd_fire;

  assign clr_mask = st_we_i ? wdata_i[N_CH-1:0] : '0;
  assign set_mask = hit_i & ie_q[N_CH-1:0];
  assign wd_fire  = hit_i[WD_CH] & wdt_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q      <= '0;
      st_q      <= '0;
      wdt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      if (ie_we_i) ie_q <= wdata_i[IE_W-1:0];
      st_q <= (st_q & ~clr_mask) | set_mask;   // set beats clear
      if (wd_fire)       wdt_q <= '0;          // one-shot disarm
      else if (wdt_we_i) wdt_q <= wdata_i;
      rst_req_q <= wd_fire;
    end
  end

  assign ie_o      = ie_q;
  assign status_o  = st_q;
  assign wdt_o     = wdt_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/os_timer_wdt.sv
module os_timer_wdt
  import os_timer_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned N_CH   = N_CH_DEF,
  parameter int unsigned IE_W   = IE_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   irq_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0]            cnt_q;
  logic [DATA_W-1:0]            cnt_inc;
  logic                         step;
  logic                         cnt_ld;
  logic [N_CH-1:0]              ch_we;
  logic [N_CH-1:0]              hit;
  logic [N_CH-1:0][DATA_W-1:0]  match_val;
  logic [IE_W-1:0]              ie;
  logic [N_CH-1:0]              status;
  logic [DATA_W-1:0]            wdt;

  assign cnt_ld = we_i && (addr_i == ADDR_W'(OFS_CNT));

  os_timer_counter #(.W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (cnt_ld),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_q),
    .cnt_inc_o  (cnt_inc),
    .step_o     (step)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_we[g] = we_i && (addr_i == ADDR_W'(g * CH_STRIDE));
    os_timer_match_ch #(.W(DATA_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (ch_we[g]),
      .wdata_i   (wdata_i),
      .cnt_inc_i (cnt_inc),
      .step_i    (step),
      .match_o   (match_val[g]),
      .hit_o     (hit[g])
    );
  end

  os_timer_evt #(.W(DATA_W), .N_CH(N_CH), .IE_W(IE_W)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ie_we_i   (we_i && (addr_i == ADDR_W'(OFS_IE))),
    .st_we_i   (we_i && (addr_i == ADDR_W'(OFS_STAT))),
    .wdt_we_i  (we_i && (addr_i == ADDR_W'(OFS_WDT))),
    .wdata_i   (wdata_i),
    .hit_i     (hit),
    .ie_o      (ie),
    .status_o  (status),
    .wdt_o     (wdt),
    .rst_req_o (rst_req_o)
  );

  assign irq_o = status;

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N_CH; n++)
      if (addr_i == ADDR_W'(n * CH_STRIDE)) rdata_o = match_val[n];
    if (addr_i == ADDR_W'(OFS_CNT))  rdata_o = cnt_q;
    if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = DATA_W'(status);
    if (addr_i == ADDR_W'(OFS_WDT))  rdata_o = wdt;
    if (addr_i == ADDR_W'(OFS_IE))   rdata_o = DATA_W'(ie);
  end
endmodule

// File: rtl/os_timer_wdt_chk.sv
module os_timer_wdt_chk
  import os_timer_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned N_CH   = N_CH_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_CH-1:0]   irq_o,
  input logic              rst_req_o,
  input logic [DATA_W-1:0] cnt_i
);
  logic ld_cnt, wr_stat;
  assign ld_cnt  = we_i && (addr_i == ADDR_W'(OFS_CNT));
  assign wr_stat = we_i && (addr_i == ADDR_W'(OFS_STAT));

  p_irq_rise_needs_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_o & ~$past(irq_o))) |-> ($past(tick_i) && !$past(ld_cnt)));

  p_irq_fall_needs_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~irq_o & $past(irq_o))) |-> $past(wr_stat));

  p_rst_req_needs_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(tick_i) && !$past(ld_cnt)));

  p_rst_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(ld_cnt)) |-> $stable(cnt_i));

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_i) && !$past(ld_cnt)) |-> (cnt_i == $past(cnt_i) + DATA_W'(1)));
endmodule

bind os_timer_wdt os_timer_wdt_chk #(
  .DATA_W(DATA_W), .N_CH(N_CH), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .cnt_i     (cnt_q)
);

// File: tb/tb_os_timer_wdt.sv
module tb_os_timer_wdt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt, m_wdt;
  logic [31:0] m_mt [4];
  logic [11:0] m_ie;
  logic [3:0]  m_st;
  logic        m_rst;

  os_timer_wdt dut (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog timeout");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_mt[0];
      8'h04: return m_mt[1];
      8'h08: return m_mt[2];
      8'h0C: return m_mt[3];
      8'h10: return m_cnt;
      8'h14: return {28'd0, m_st};
      8'h18: return m_wdt;
      8'h1C: return {20'd0, m_ie};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp_read(a));
  endtask

  task automatic rd_all(input string tag);
    for (int k = 0; k < 8; k++) rd(tag, 8'(k * 4));
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic tk);
    logic ld;
    logic [3:0] h, clr;
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    ld = we && (a == 8'h10);
    h = '0;
    for (int n = 0; n < 4; n++)
      if (tk && !ld && (m_cnt + 32'd1) == m_mt[n]) h[n] = 1'b1;
    m_rst = h[3] & m_wdt[0];
    clr = (we && a == 8'h14) ? d[3:0] : 4'd0;
    m_st = (m_st & ~clr) | (h & m_ie[3:0]);
    if (we) begin
      case (a)
        8'h00: m_mt[0] = d;
        8'h04: m_mt[1] = d;
        8'h08: m_mt[2] = d;
        8'h0C: m_mt[3] = d;
        8'h18: m_wdt = d;
        8'h1C: m_ie = d[11:0];
        default: ;
      endcase
    end
    if (m_rst) m_wdt = '0;
    if (ld) m_cnt = d;
    else if (tk) m_cnt = m_cnt + 32'd1;
    @(posedge clk_i);
    #1;
    we_i = 1'b0; tick_i = 1'b0;
    chk("R5 irq", {28'd0, irq_o}, {28'd0, m_st});
    chk("R9 rst_req", {31'd0, rst_req_o}, {31'd0, m_rst});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic tk();
    step(1'b0, 8'h00, 32'd0, 1'b1);
  endtask

  initial begin
    logic [7:0] amap [9];
    amap = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};
    void'($urandom(32'd20240611));
    m_cnt = '0; m_wdt = '0; m_ie = '0; m_st = '0; m_rst = 1'b0;
    for (int n = 0; n < 4; n++) m_mt[n] = '0;

    repeat (3) @(negedge clk_i);
    // R1: reset values
    rd_all("R1 reset read");
    chk("R1 irq reset", {28'd0, irq_o}, 32'd0);
    chk("R1 rst_req reset", {31'd0, rst_req_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: compare readback
    for (int n = 0; n < 4; n++) begin
      logic [31:0] v;
      v = $urandom;
      wr(8'(n * 4), v);
      rd("R2 match readback", 8'(n * 4));
    end

    // R4: enable mask
    wr(8'h1C, 32'hFFFF_FFFF);
    addr_i = 8'h1C; #1; chk("R4 ie mask", rdata_o, 32'h0000_0FFF);
    wr(8'h1C, 32'd0);

    // R3: load, count, hold, wrap
    wr(8'h10, 32'h0000_0100);
    repeat (5) tk();
    addr_i = 8'h10; #1; chk("R3 count", rdata_o, 32'h0000_0105);
    repeat (3) step(1'b0, 8'h00, 32'd0, 1'b0);
    addr_i = 8'h10; #1; chk("R3 hold", rdata_o, 32'h0000_0105);
    wr(8'h10, 32'hFFFF_FFFE);
    repeat (3) tk();
    addr_i = 8'h10; #1; chk("R3 wrap", rdata_o, 32'h0000_0001);
    step(1'b1, 8'h10, 32'h0000_0040, 1'b1);
    addr_i = 8'h10; #1; chk("R3 load beats tick", rdata_o, 32'h0000_0040);

    // R5 / R6: enabled channel 0, disabled channel 1
    wr(8'h00, 32'h20); wr(8'h04, 32'h21); wr(8'h08, 32'h1000); wr(8'h0C, 32'h1000);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'h1E);
    tk();
    chk("R5 no early match", {28'd0, irq_o}, 32'd0);
    tk();
    chk("R5 irq0 on match", {28'd0, irq_o}, 32'h1);
    tk();
    chk("R6 disabled ch1 irq", {28'd0, irq_o}, 32'h1);
    rd("R6 status", 8'h14);

    // R7: write-one-to-clear
    wr(8'h14, 32'h2);
    addr_i = 8'h14; #1; chk("R7 no clear of unset", rdata_o, 32'h1);
    wr(8'h14, 32'h1);
    addr_i = 8'h14; #1; chk("R7 clear", rdata_o, 32'h0);

    // R8: event beats clear on the same bit
    wr(8'h08, 32'h50); wr(8'h1C, 32'h5);
    wr(8'h10, 32'h4E); tk();
    wr(8'h14, 32'h4);
    step(1'b1, 8'h14, 32'h4, 1'b1);
    addr_i = 8'h14; #1; chk("R8 set wins", rdata_o, 32'h4);
    wr(8'h14, 32'hF);

    // R9: watchdog with irq3 disabled
    wr(8'h0C, 32'h80); wr(8'h18, 32'h1);
    wr(8'h10, 32'h7E);
    tk();
    chk("R9 no early reset", {31'd0, rst_req_o}, 32'd0);
    tk();
    chk("R9 reset pulse", {31'd0, rst_req_o}, 32'h1);
    chk("R9 irq3 stays low", {31'd0, irq_o[3]}, 32'd0);
    addr_i = 8'h18; #1; chk("R9 wdt disarmed", rdata_o, 32'd0);
    tk();
    chk("R9 pulse ends", {31'd0, rst_req_o}, 32'd0);
    // watchdog write in the firing cycle loses
    wr(8'h18, 32'h1); wr(8'h10, 32'h7F);
    step(1'b1, 8'h18, 32'h3, 1'b1);
    chk("R9 fire with write", {31'd0, rst_req_o}, 32'h1);
    addr_i = 8'h18; #1; chk("R9 wdt cleared over write", rdata_o, 32'd0);

    // R10: disarmed watchdog
    wr(8'h10, 32'h7F);
    tk();
    chk("R10 no reset", {31'd0, rst_req_o}, 32'd0);

    // R11: unmapped offsets
    wr(8'h24, 32'hDEAD_BEEF); wr(8'h01, 32'h1234_5678); wr(8'h40, 32'hFFFF_FFFF);
    addr_i = 8'h24; #1; chk("R11 unmapped read", rdata_o, 32'd0);
    addr_i = 8'h03; #1; chk("R11 unaligned read", rdata_o, 32'd0);
    rd_all("R11 regs untouched");

    // R12: load onto a compare value
    wr(8'h14, 32'hF); wr(8'h1C, 32'hF); wr(8'h00, 32'h33);
    wr(8'h10, 32'h33);
    chk("R12 load no match", {28'd0, irq_o}, 32'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic we;
      logic [7:0] a;
      logic [31:0] d;
      we = ($urandom % 10) < 3;
      a = amap[$urandom % 9];
      if (a == 8'h10 || a <= 8'h0C) d = $urandom % 64;
      else if (a == 8'h18) d = $urandom % 2;
      else d = $urandom;
      step(we, a, d, ($urandom % 10) < 7);
      if (i % 25 == 0) rd_all("R2 R3 R4 R7 random readback");
    end
    rd_all("R5 final readback");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule